// File: doc/BRIEF.md
# Bank Override Output Resolver

This block turns the register state of a 40-pin general-purpose output stage into the per-pin drive signals a pad ring consumes. The pins are grouped into five banks of eight. Each bank has an output-value register and a direction register. Two shared registers shape the result:

- A bank-override register can drive chosen banks to a constant level without altering their output-value registers.
- A drive-style register picks open-drain or push-pull drive. It works per pin pair in bank 0 and per whole bank elsewhere.

Software, or a serial-bus front end, programs the block through a single-cycle write port of address, data and enable. For every pin the block presents three signals: the level to drive, an output enable, and an open-drain flag. All three are combinational functions of the stored state, so a write is visible on the pins in the cycle after the clock edge that captures it.

Top module: `bor_resolver`

## Requirements
- R1: While reset is asserted and afterwards until written, the output-value registers hold 00h, the direction registers hold 00h (all pins are inputs), the drive-style register holds FFh and the bank-override register holds 80h. With these values no override is in effect.
- R2: The output-value register of bank k sits at address 08h+k (k = 0..4). The direction register of bank k sits at 18h+k, where bit value 1 makes the pin an output. An output pin in a bank without an active override drives bit p of its bank's output-value register on pin 8k+p, one cycle after the write.
- R3: The bank-override register sits at address 29h. Bit 7 is the polarity bit and bit k (k = 0..4) belongs to bank k. When the polarity bit is 0, every bank whose bit is 0 drives 0 on all its output pins, and a bank whose bit is 1 keeps its register value.
- R4: When the polarity bit is 1, every bank whose bit is 1 drives 1 on all its output pins, and a bank whose bit is 0 keeps its register value.
- R5: A write to the bank-override register leaves the output-value registers unchanged. Rewriting it with a pattern that overrides nothing shows the earlier register contents on the pins again.
- R6: A write to the output-value register of bank k ends the override for bank k only. Its pins then follow the register, other banks stay overridden, and the next bank-override write re-applies to all banks.
- R7: Bits 6:5 of the bank-override register have no effect on any pin.
- R8: The drive-style register sits at address 28h. Bits 3:0 each serve a pair of bank-0 pins, bit j serving pins 2j and 2j+1. Bits 7:4 serve banks 1 to 4 whole, with bit 3+k serving bank k. Value 0 selects open-drain and 1 selects push-pull, and the open-drain flag of an output pin follows this choice.
- R9: An open-drain output pin enables its driver only while its level is 0 and releases it while its level is 1. A push-pull output pin is always enabled. No pin ever drives a high level with its open-drain flag set.
- R10: An input pin has its level, output enable and open-drain flag all at 0, whatever the override and drive-style settings.
- R11: A write to any address other than 08h-0Ch, 18h-1Ch, 28h and 29h changes no register and no pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe for one cycle |
| wr_addr | input | 7 | Register address of the write |
| wr_data | input | 8 | Register data of the write |
| pin_data | output | 40 | Level to drive; bit 8k+p is pin p of bank k |
| pin_oe | output | 40 | Output driver enable per pin |
| pin_od | output | 40 | Open-drain flag per pin |

## Verification
The hardest state to reach is a mixed override: some banks are released by a later output-value write while the rest stay forced. A further step shows that the released bank is forced again by the next override write. The bench builds this in steps. It forces all banks high, writes one bank's output-value register, and rewrites the same override value. It then writes an override pattern that forces nothing, which exposes the output-value registers untouched beneath the override. The drive-style mapping is then swept with masks that split bank 0 into pairs, with the banks set to both directions and both override polarities.

// File: rtl/bor_pkg.sv
package bor_pkg;

    localparam int NUM_BANKS  = 5;
    localparam int BANK_W     = 8;
    localparam int PIN_CNT    = NUM_BANKS * BANK_W;
    localparam int REG_W      = 8;
    localparam int ADDR_W     = 7;
    localparam int IDX_W      = $clog2(NUM_BANKS);
    localparam int PAIR_BITS  = BANK_W / 2;

    localparam logic [ADDR_W-1:0] A_PORT_BASE = 7'h08;
    localparam logic [ADDR_W-1:0] A_PORT_END  = A_PORT_BASE + ADDR_W'(NUM_BANKS);
    localparam logic [ADDR_W-1:0] A_DIR_BASE  = 7'h18;
    localparam logic [ADDR_W-1:0] A_DIR_END   = A_DIR_BASE + ADDR_W'(NUM_BANKS);
    localparam logic [ADDR_W-1:0] A_STYLE     = 7'h28;
    localparam logic [ADDR_W-1:0] A_ALLBANK   = 7'h29;

    localparam logic [REG_W-1:0]  STYLE_RST   = 8'hFF;
    localparam logic              POL_RST     = 1'b1;
    localparam int                POL_BIT     = REG_W - 1;

    typedef logic [BANK_W-1:0]                   bank_t;
    typedef logic [NUM_BANKS-1:0][BANK_W-1:0]    bank_vec_t;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_PORT,
        REG_DIR,
        REG_STYLE,
        REG_ALLBANK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } decode_t;

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.kind = REG_NONE;
        d.idx  = '0;
        if (a >= A_PORT_BASE && a < A_PORT_END) begin
            d.kind = REG_PORT;
            d.idx  = IDX_W'(a - A_PORT_BASE);
        end else if (a >= A_DIR_BASE && a < A_DIR_END) begin
            d.kind = REG_DIR;
            d.idx  = IDX_W'(a - A_DIR_BASE);
        end else if (a == A_STYLE) begin
            d.kind = REG_STYLE;
        end else if (a == A_ALLBANK) begin
            d.kind = REG_ALLBANK;
        end
        return d;
    endfunction

    // 1 = push-pull for pin 'pin' of bank 'bank'
    function automatic logic style_bit(input logic [REG_W-1:0] cfg,
                                       input int bank, input int pin);
        if (bank == 0)
            return cfg[pin / 2];
        return cfg[PAIR_BITS + bank - 1];
    endfunction

endpackage

// File: rtl/bor_regs.sv
module bor_regs
    import bor_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    output bank_vec_t            port_q,
    output bank_vec_t            dir_q,
    output logic [REG_W-1:0]     style_q,
    output logic                 ab_pol_q,
    output logic [NUM_BANKS-1:0] ab_bits_q,
    output logic [NUM_BANKS-1:0] port_wr,
    output logic                 ab_wr
);

    decode_t              dec;
    logic [NUM_BANKS-1:0] dir_wr;
    logic                 style_wr;

    always_comb begin
        dec      = decode_addr(wr_addr);
        ab_wr    = wr_en && (dec.kind == REG_ALLBANK);
        style_wr = wr_en && (dec.kind == REG_STYLE);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
        assign port_wr[b] = wr_en && (dec.kind == REG_PORT) && (dec.idx == IDX_W'(b));
        assign dir_wr[b]  = wr_en && (dec.kind == REG_DIR)  && (dec.idx == IDX_W'(b));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            port_q <= '0;
            dir_q  <= '0;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (port_wr[b]) port_q[b] <= wr_data;
                if (dir_wr[b])  dir_q[b]  <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            style_q   <= STYLE_RST;
            ab_pol_q  <= POL_RST;
            ab_bits_q <= '0;
        end else begin
            if (style_wr) style_q <= wr_data;
            if (ab_wr) begin
                ab_pol_q  <= wr_data[POL_BIT];
                ab_bits_q <= wr_data[NUM_BANKS-1:0];
            end
        end
    end

endmodule

// File: rtl/bor_override.sv
module bor_override
    import bor_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ab_pol,
    input  logic [NUM_BANKS-1:0] ab_bits,
    input  logic                 ab_wr,
    input  logic [NUM_BANKS-1:0] port_wr,
    output logic [NUM_BANKS-1:0] armed_q,
    output logic [NUM_BANKS-1:0] force_en,
    output logic                 force_val
);

    // a bank stays armed from an override write until its own register write
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= '0;
        end else if (ab_wr) begin
            armed_q <= '1;
        end else begin
            armed_q <= armed_q & ~port_wr;
        end
    end

    assign force_val = ab_pol;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_force
        assign force_en[b] = armed_q[b] && (ab_bits[b] == ab_pol);
    end

endmodule

// File: rtl/bor_bank_drive.sv
module bor_bank_drive
    import bor_pkg::*;
#(
    parameter int BANK_IDX = 0
)(
    input  bank_t            port_val,
    input  bank_t            dir_val,
    input  logic [REG_W-1:0] style_cfg,
    input  logic             force_en,
    input  logic             force_val,
    output bank_t            drv_data,
    output bank_t            drv_en,
    output bank_t            drv_od
);

    for (genvar p = 0; p < BANK_W; p++) begin : g_pin
        logic push_pull;
        logic level;
        assign push_pull   = style_bit(style_cfg, BANK_IDX, p);
        assign level       = force_en ? force_val : port_val[p];
        assign drv_data[p] = dir_val[p] & level;
        assign drv_od[p]   = dir_val[p] & ~push_pull;
        assign drv_en[p]   = dir_val[p] & (push_pull | ~level);
    end

endmodule

// File: rtl/bor_resolver.sv
module bor_resolver
    import bor_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [REG_W-1:0]      wr_data,
    output logic [PIN_CNT-1:0]    pin_data,
    output logic [PIN_CNT-1:0]    pin_oe,
    output logic [PIN_CNT-1:0]    pin_od
);

    bank_vec_t            port_q;
    bank_vec_t            dir_q;
    logic [REG_W-1:0]     style_q;
    logic                 ab_pol_q;
    logic [NUM_BANKS-1:0] ab_bits_q;
    logic [NUM_BANKS-1:0] port_wr;
    logic                 ab_wr;
    logic [NUM_BANKS-1:0] armed_q;
    logic [NUM_BANKS-1:0] force_en;
    logic                 force_val;

    bor_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .port_q    (port_q),
        .dir_q     (dir_q),
        .style_q   (style_q),
        .ab_pol_q  (ab_pol_q),
        .ab_bits_q (ab_bits_q),
        .port_wr   (port_wr),
        .ab_wr     (ab_wr)
    );

    bor_override u_ovr (
        .clk       (clk),
        .rst       (rst),
        .ab_pol    (ab_pol_q),
        .ab_bits   (ab_bits_q),
        .ab_wr     (ab_wr),
        .port_wr   (port_wr),
        .armed_q   (armed_q),
        .force_en  (force_en),
        .force_val (force_val)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bor_bank_drive #(.BANK_IDX(b)) u_drv (
            .port_val  (port_q[b]),
            .dir_val   (dir_q[b]),
            .style_cfg (style_q),
            .force_en  (force_en[b]),
            .force_val (force_val),
            .drv_data  (pin_data[b*BANK_W +: BANK_W]),
            .drv_en    (pin_oe[b*BANK_W +: BANK_W]),
            .drv_od    (pin_od[b*BANK_W +: BANK_W])
        );
    end

endmodule

// File: rtl/bor_checker.sv
module bor_checker
    import bor_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [PIN_CNT-1:0]   pin_data,
    input logic [PIN_CNT-1:0]   pin_oe,
    input logic [PIN_CNT-1:0]   pin_od,
    input logic [PIN_CNT-1:0]   port_bits,
    input logic [PIN_CNT-1:0]   dir_bits,
    input logic [REG_W-1:0]     style_bits,
    input logic                 ab_pol,
    input logic [NUM_BANKS-1:0] ab_bits,
    input logic [NUM_BANKS-1:0] armed
);

    // R1: first cycle out of reset, nothing is driven
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && pin_od == '0 && pin_data == '0));

    // R9: an open-drain pin never drives a high level
    p_od_never_high_r9: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & pin_od & pin_data) == '0);

    // R10: input pins stay quiet
    p_input_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe | pin_od | pin_data) & ~dir_bits) == '0);

    // R5: override writes leave the output-value registers alone
    p_allbank_keeps_port_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_ALLBANK) |=> $stable(port_bits));

    // R11: unmapped writes change no register
    p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && decode_addr(wr_addr).kind == REG_NONE) |=>
            ($stable(port_bits) && $stable(dir_bits) && $stable(style_bits)
             && $stable(ab_pol) && $stable(ab_bits)));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        // R3: forced-low bank shows no high level
        p_force_low_r3: assert property (@(posedge clk) disable iff (rst)
            (!ab_pol && armed[b] && !ab_bits[b]) |->
                (pin_data[b*BANK_W +: BANK_W] == '0));
        // R4: forced-high bank shows high on exactly its output pins
        p_force_high_r4: assert property (@(posedge clk) disable iff (rst)
            (ab_pol && armed[b] && ab_bits[b]) |->
                (pin_data[b*BANK_W +: BANK_W] == dir_bits[b*BANK_W +: BANK_W]));
    end

endmodule

bind bor_resolver bor_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .pin_data   (pin_data),
    .pin_oe     (pin_oe),
    .pin_od     (pin_od),
    .port_bits  (port_q),
    .dir_bits   (dir_q),
    .style_bits (style_q),
    .ab_pol     (ab_pol_q),
    .ab_bits    (ab_bits_q),
    .armed      (armed_q)
);

// File: tb/sim_bor_resolver.sv
module sim_bor_resolver;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [39:0] pin_data, pin_oe, pin_od;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bor_resolver u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pin_data(pin_data), .pin_oe(pin_oe), .pin_od(pin_od)
    );

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R1", "oe after reset", pin_oe, 40'h0);
        chk("R1", "od after reset", pin_od, 40'h0);
        chk("R1", "data after reset", pin_data, 40'h0);
    endtask

    task automatic t_plain();
        for (int k = 0; k < 5; k++) wr(7'h18 + 7'(k), 8'hFF);
        chk("R1", "data with default registers", pin_data, 40'h0);
        chk("R1", "oe with default push-pull", pin_oe, {40{1'b1}});
        chk("R1", "od with default push-pull", pin_od, 40'h0);
        wr(7'h08, 8'hA5); wr(7'h09, 8'h3C); wr(7'h0A, 8'hF0);
        wr(7'h0B, 8'h0F); wr(7'h0C, 8'h96);
        chk("R2", "register values on pins", pin_data, 40'h960FF03CA5);
    endtask

    task automatic t_force_low();
        wr(7'h29, 8'h06);
        chk("R3", "polarity 0 mask 06", pin_data, 40'h0000F03C00);
        wr(7'h29, 8'h66);
        chk("R7", "spare bits set, polarity 0", pin_data, 40'h0000F03C00);
    endtask

    task automatic t_force_high();
        wr(7'h29, 8'h8C);
        chk("R4", "polarity 1 mask 0C", pin_data, 40'h96FFFF3CA5);
        wr(7'h29, 8'hE0);
        chk("R5", "registers intact after override", pin_data, 40'h960FF03CA5);
    endtask

    task automatic t_release();
        wr(7'h29, 8'h9F);
        chk("R4", "all banks forced high", pin_data, {40{1'b1}});
        wr(7'h09, 8'h5A);
        chk("R6", "bank 1 released by its write", pin_data, 40'hFFFFFF5AFF);
        wr(7'h29, 8'h9F);
        chk("R6", "override write re-arms bank 1", pin_data, {40{1'b1}});
        wr(7'h29, 8'h80);
        chk("R5", "registers shown again", pin_data, 40'h960FF05AA5);
    endtask

    task automatic t_style();
        wr(7'h28, 8'h00);
        chk("R8", "all open-drain od", pin_od, {40{1'b1}});
        chk("R9", "all open-drain oe", pin_oe, 40'h69F00FA55A);
        chk("R9", "open-drain data", pin_data, 40'h960FF05AA5);
        wr(7'h28, 8'h05);
        chk("R8", "bank0 pairs 0,2 push-pull od", pin_od, 40'hFFFFFFFFCC);
        chk("R9", "bank0 pairs mix oe", pin_oe, 40'h69F00FA57B);
        wr(7'h28, 8'hA0);
        chk("R8", "banks 2,4 push-pull od", pin_od, 40'h00FF00FFFF);
        chk("R9", "banks 2,4 push-pull oe", pin_oe, 40'hFFF0FFA55A);
        wr(7'h28, 8'h00);
        wr(7'h29, 8'h9F);
        chk("R9", "forced high open-drain releases", pin_oe, 40'h0);
        chk("R4", "forced high open-drain data", pin_data, {40{1'b1}});
    endtask

    task automatic t_inputs();
        wr(7'h28, 8'hFF);
        wr(7'h1A, 8'h0F);
        wr(7'h1C, 8'h00);
        chk("R10", "mixed direction data", pin_data, 40'h00FF0FFFFF);
        chk("R10", "mixed direction oe", pin_oe, 40'h00FF0FFFFF);
        chk("R10", "mixed direction od", pin_od, 40'h0);
        wr(7'h28, 8'h00);
        chk("R10", "open-drain od only on outputs", pin_od, 40'h00FF0FFFFF);
        chk("R10", "released open-drain oe", pin_oe, 40'h0);
    endtask

    task automatic t_unmapped();
        wr(7'h0D, 8'h00); wr(7'h1D, 8'hFF); wr(7'h27, 8'hFF);
        wr(7'h2A, 8'h00); wr(7'h7F, 8'h00); wr(7'h00, 8'h00);
        chk("R11", "data after unmapped writes", pin_data, 40'h00FF0FFFFF);
        chk("R11", "od after unmapped writes", pin_od, 40'h00FF0FFFFF);
        wr(7'h28, 8'hFF);
        chk("R11", "oe after style restore", pin_oe, 40'h00FF0FFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_force_low();
        t_force_high();
        t_release();
        t_style();
        t_inputs();
        t_unmapped();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule